// File: doc/BRIEF.md
# Multi-Mode Pin Capture Front End

This block sits between a processor's register port and one core's general-purpose pins: 16 outputs and 17 inputs. A two-bit mode select sets how the pins are used. In direct mode the pins follow the output register, and the input pins can be read back. In serial mode a 28-bit word shifts out on one pin and in on another, with a shift clock on a third pin. In parallel mode a 16-bit word is sampled on each rising edge of an external capture clock. In nibble-receive mode, 4-bit nibbles that arrive with a 25 MHz receive clock are paired into bytes, which carries a 100 Mbit/s media-independent receive stream.

All input pins, including the pin that carries the external capture clock, pass through a two-flop synchronizer. Clock edges are found by comparing the synchronized level on the system clock. Software writes through `wrEn`/`wrData` and reads `rdData`. One `valid` flag marks a finished result in the current mode, and a read strobe clears it.

Top module: `pin_mode_frontend`

## Requirements
- R1: While reset is held and after it is released, `pinOut` is 0, `valid` is 0, the mode is direct, and with all input pins low `rdData` is 0.
- R2: In direct mode, a write puts `wrData[15:0]` on `pinOut` at the next clock edge. `rdData` is `{15'b0, pinIn}` delayed by exactly two clock edges. `valid` stays 0.
- R3: `modeSel` is encoded as 0 for direct, 1 for serial, 2 for parallel and 3 for nibble receive. A new value takes effect at the next clock edge. That same edge clears `valid`, the serial bit counter and any unpaired nibble.
- R4: In serial mode, a write loads `wrData[27:0]` and starts a transfer. `pinOut[0]` shows the word's MSB right after the loading edge and the next lower bit after each following edge, for 28 bits in total.
- R5: During a serial transfer, `pinOut[1]` (the shift clock) is low after the load, changes level once per bit, and is low again after the 28th bit.
- R6: In serial mode, each bit step shifts the synchronized `pinIn[0]` into the LSB of the word. On the 28th step `valid` rises and `rdData` becomes `{4'b0, received word}`.
- R7: In serial mode a write does not change `pinOut[15:2]`, which keeps the output register's value.
- R8: In parallel mode, each rising edge of the synchronized `pinIn[16]` stores the synchronized `pinIn[15:0]`. It raises `valid`, and `rdData` becomes `{16'b0, word}`. The result appears three clock edges after the pin change.
- R9: In nibble-receive mode, each rising edge of the synchronized `pinIn[16]` takes `pinIn[3:0]`. The first nibble is the low half of a byte and the second is the high half. `valid` rises only after the second nibble, with `rdData = {24'b0, high, low}`. Pins 15:4 are ignored.
- R10: A read strobe (`rdEn`) clears `valid` at the next edge. If a new result completes at that same edge, `valid` stays 1 and `rdData` holds the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Mode: 0 direct, 1 serial, 2 parallel, 3 nibble receive |
| wrEn | input | 1 | Write strobe |
| wrData | input | 28 | Write data: output pins in direct/parallel/nibble modes, shift word in serial mode |
| rdEn | input | 1 | Read acknowledge, clears `valid` |
| rdData | output | 32 | Mode-dependent read data |
| valid | output | 1 | Result ready in the current mode |
| pinIn | input | 17 | Input pins; bit 16 is the capture clock, bit 0 is the serial input |
| pinOut | output | 16 | Output pins; in serial mode bit 0 is data and bit 1 is the shift clock |

## Verification
The main collision is between a read acknowledge and a new completion. Software may clear `valid` in the same cycle that a capture edge or the last serial bit sets it again. The bench provokes this by raising the capture clock pin and timing `rdEn` so that it is sampled on the third edge after that, which is the edge where the capture lands. It then requires `valid` to still be 1 and `rdData` to hold the new word, and it requires a later lone `rdEn` to clear the flag. A second overlap comes from a mode change arriving while a nibble pair is half complete. The bench judges this by checking that the next pair after switching back starts from a fresh low nibble.

// File: rtl/pin_mode_pkg.sv
package pin_mode_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_SERIAL   = 2'd1,
    MODE_PARALLEL = 2'd2,
    MODE_NIBBLE   = 2'd3
  } pinMode_e;

  // Strobes from control to datapath, valid for one clock each
  typedef struct packed {
    logic clearAll;   // mode changed: drop partial state
    logic writeOut;   // load output register
    logic loadShift;  // load serial word, restart transfer
    logic doShift;    // advance serial shifter by one bit
    logic capWord;    // store parallel word
    logic capLowNib;  // store first nibble of a pair
    logic capByte;    // assemble byte from stored and current nibble
  } ctrlStrobe_t;

endpackage

// File: rtl/pin_mode_sync.sv
module pin_mode_sync #(
  parameter int WIDTH  = 17,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stageQ[s] <= '0;
        end else begin
          if (s == 0) stageQ[s] <= din;
          else        stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/pin_mode_ctrl.sv
module pin_mode_ctrl
  import pin_mode_pkg::*;
#(
  parameter int SHIFT_W = 28
) (
  input  logic        clk,
  input  logic        rstN,
  input  pinMode_e    modeSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        capEdge,
  output pinMode_e    modeQ,
  output ctrlStrobe_t strobe,
  output logic        valid
);

  localparam int CNT_W = $clog2(SHIFT_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SHIFT_W - 1);

  logic             modeChg;
  logic             busyQ;
  logic             halfQ;
  logic [CNT_W-1:0] bitCntQ;
  logic             lastBit;
  logic             setValid;

  assign modeChg = (modeSel != modeQ);

  always_comb begin
    strobe          = '0;
    strobe.clearAll = modeChg;
    strobe.writeOut = wrEn && (modeQ != MODE_SERIAL);
    if (!modeChg) begin
      strobe.loadShift = wrEn && (modeQ == MODE_SERIAL);
      strobe.doShift   = busyQ && !strobe.loadShift;
      strobe.capWord   = capEdge && (modeQ == MODE_PARALLEL);
      strobe.capLowNib = capEdge && (modeQ == MODE_NIBBLE) && !halfQ;
      strobe.capByte   = capEdge && (modeQ == MODE_NIBBLE) && halfQ;
    end
  end

  assign lastBit  = strobe.doShift && (bitCntQ == LAST_BIT);
  assign setValid = lastBit || strobe.capWord || strobe.capByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_DIRECT;
      busyQ   <= 1'b0;
      halfQ   <= 1'b0;
      bitCntQ <= '0;
      valid   <= 1'b0;
    end else begin
      modeQ <= modeSel;
      if (strobe.clearAll) begin
        busyQ   <= 1'b0;
        halfQ   <= 1'b0;
        bitCntQ <= '0;
        valid   <= 1'b0;
      end else begin
        if (strobe.loadShift) begin
          busyQ   <= 1'b1;
          bitCntQ <= '0;
        end else if (strobe.doShift) begin
          bitCntQ <= bitCntQ + CNT_W'(1);
          if (lastBit) busyQ <= 1'b0;
        end
        if (strobe.capLowNib)    halfQ <= 1'b1;
        else if (strobe.capByte) halfQ <= 1'b0;
        if (setValid)                      valid <= 1'b1;
        else if (strobe.loadShift || rdEn) valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pin_mode_datapath.sv
module pin_mode_datapath
  import pin_mode_pkg::*;
#(
  parameter int OUT_W       = 16,
  parameter int IN_W        = 17,
  parameter int SHIFT_W     = 28,
  parameter int PAR_W       = 16,
  parameter int NIB_W       = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  pinMode_e           modeQ,
  input  ctrlStrobe_t        strobe,
  input  logic [SHIFT_W-1:0] wrData,
  input  logic [IN_W-1:0]    pinIn,
  output logic [OUT_W-1:0]   pinOut,
  output logic [DATA_W-1:0]  rdData,
  output logic               capEdge
);

  localparam int CLK_BIT = IN_W - 1;
  localparam int BYTE_W  = 2 * NIB_W;

  logic [IN_W-1:0]    pinSync;
  logic               edgePrevQ;
  logic [OUT_W-1:0]   outRegQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic               sclkQ;
  logic [PAR_W-1:0]   capWordQ;
  logic [NIB_W-1:0]   lowNibQ;
  logic [BYTE_W-1:0]  byteQ;

  pin_mode_sync #(
    .WIDTH (IN_W),
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din (pinIn),
    .dout(pinSync)
  );

  assign capEdge = pinSync[CLK_BIT] && !edgePrevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgePrevQ <= 1'b0;
      outRegQ   <= '0;
      shiftQ    <= '0;
      sclkQ     <= 1'b0;
      capWordQ  <= '0;
      lowNibQ   <= '0;
      byteQ     <= '0;
    end else begin
      edgePrevQ <= pinSync[CLK_BIT];
      if (strobe.writeOut) outRegQ <= wrData[OUT_W-1:0];
      if (strobe.clearAll) begin
        shiftQ <= '0;
        sclkQ  <= 1'b0;
      end else if (strobe.loadShift) begin
        shiftQ <= wrData;
        sclkQ  <= 1'b0;
      end else if (strobe.doShift) begin
        shiftQ <= {shiftQ[SHIFT_W-2:0], pinSync[0]};
        sclkQ  <= !sclkQ;
      end
      if (strobe.capWord)   capWordQ <= pinSync[PAR_W-1:0];
      if (strobe.capLowNib) lowNibQ  <= pinSync[NIB_W-1:0];
      if (strobe.capByte)   byteQ    <= {pinSync[NIB_W-1:0], lowNibQ};
    end
  end

  always_comb begin
    pinOut = outRegQ;
    if (modeQ == MODE_SERIAL) begin
      pinOut[0] = shiftQ[SHIFT_W-1];
      pinOut[1] = sclkQ;
    end
  end

  always_comb begin
    unique case (modeQ)
      MODE_DIRECT:   rdData = DATA_W'(pinSync);
      MODE_SERIAL:   rdData = DATA_W'(shiftQ);
      MODE_PARALLEL: rdData = DATA_W'(capWordQ);
      default:       rdData = DATA_W'(byteQ);
    endcase
  end

endmodule

// File: rtl/pin_mode_frontend.sv
module pin_mode_frontend
  import pin_mode_pkg::*;
#(
  parameter int OUT_W       = 16,
  parameter int IN_W        = 17,
  parameter int SHIFT_W     = 28,
  parameter int PAR_W       = 16,
  parameter int NIB_W       = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic               wrEn,
  input  logic [SHIFT_W-1:0] wrData,
  input  logic               rdEn,
  output logic [DATA_W-1:0]  rdData,
  output logic               valid,
  input  logic [IN_W-1:0]    pinIn,
  output logic [OUT_W-1:0]   pinOut
);

  pinMode_e    modeQ;
  ctrlStrobe_t strobe;
  logic        capEdge;

  pin_mode_ctrl #(
    .SHIFT_W(SHIFT_W)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(pinMode_e'(modeSel)),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .capEdge(capEdge),
    .modeQ  (modeQ),
    .strobe (strobe),
    .valid  (valid)
  );

  pin_mode_datapath #(
    .OUT_W      (OUT_W),
    .IN_W       (IN_W),
    .SHIFT_W    (SHIFT_W),
    .PAR_W      (PAR_W),
    .NIB_W      (NIB_W),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) data_i (
    .clk    (clk),
    .rstN   (rstN),
    .modeQ  (modeQ),
    .strobe (strobe),
    .wrData (wrData),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .rdData (rdData),
    .capEdge(capEdge)
  );

endmodule

// File: rtl/pin_mode_chk.sv
module pin_mode_chk
  import pin_mode_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input pinMode_e         modeQ,
  input logic             doShift,
  input logic             capDone,
  input logic             capEdge,
  input logic             valid,
  input logic             wrEn,
  input logic             rdEn,
  input logic [OUT_W-1:0] wrLow,
  input logic [OUT_W-1:0] pinOut
);

  // R3
  mode_change_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != modeQ) |=> !valid);

  // R2
  direct_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_DIRECT) |-> !valid);

  // R2
  direct_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && $past(modeQ) == MODE_DIRECT && modeQ == MODE_DIRECT)
      |-> (pinOut == $past(wrLow)));

  // R5
  sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doShift |=> (pinOut[1] != $past(pinOut[1])));

  // R8
  par_valid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(valid) && modeQ == MODE_PARALLEL) |-> $past(capEdge));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && rdEn && !capDone && !doShift && modeSel == modeQ) |=> !valid);

endmodule

bind pin_mode_frontend pin_mode_chk #(.OUT_W(OUT_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .modeSel(modeSel),
  .modeQ  (modeQ),
  .doShift(strobe.doShift),
  .capDone(strobe.capWord | strobe.capByte),
  .capEdge(capEdge),
  .valid  (valid),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .wrLow  (wrData[OUT_W-1:0]),
  .pinOut (pinOut)
);

// File: tb/pin_mode_frontend_tb_top.sv
module pin_mode_frontend_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  modeSel;
  logic        wrEn;
  logic [27:0] wrData;
  logic        rdEn;
  logic [31:0] rdData;
  logic        valid;
  logic [16:0] pinIn;
  logic [15:0] pinOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pin_mode_frontend dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .valid(valid), .pinIn(pinIn), .pinOut(pinOut)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] first;
    logic [15:0] second;
    logic [31:0] expData;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd2, 16'hBEEF, 16'h0000, 32'h0000BEEF},
    '{2'd2, 16'h0001, 16'h0000, 32'h00000001},
    '{2'd2, 16'h8000, 16'h0000, 32'h00008000},
    '{2'd3, 16'h000A, 16'h0005, 32'h0000005A},
    '{2'd3, 16'h7FA3, 16'h12C4, 32'h00000043},
    '{2'd3, 16'h000F, 16'h0000, 32'h0000000F}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk) modeSel = m;
    @(negedge clk);
  endtask

  task automatic capPulse(input logic [15:0] data);
    @(negedge clk) pinIn = {1'b0, data};
    repeat (3) @(negedge clk);
    pinIn = {1'b1, data};
    repeat (4) @(negedge clk);
    pinIn = {1'b0, data};
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [27:0] word;
    rstN = 1'b0; modeSel = 2'd0; wrEn = 1'b0; wrData = '0; rdEn = 1'b0; pinIn = '0;
    repeat (3) @(negedge clk);
    check("R1 pinOut in reset", 32'(pinOut), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pinOut", 32'(pinOut), 32'h0);
    check("R1 valid", 32'(valid), 32'h0);
    check("R1 rdData", rdData, 32'h0);

    // R2 direct write and pin read-back latency
    @(negedge clk) begin wrEn = 1'b1; wrData = 28'hEAD1234; end
    @(negedge clk) wrEn = 1'b0;
    check("R2 pinOut after write", 32'(pinOut), 32'h1234);
    pinIn = 17'h1ABCD;
    repeat (2) @(negedge clk);
    check("R2 rdData pins", rdData, 32'h0001ABCD);
    pinIn = 17'h05555;
    @(negedge clk);
    check("R2 one edge later still old", rdData, 32'h0001ABCD);
    @(negedge clk);
    check("R2 two edges later new", rdData, 32'h00005555);
    check("R2 valid low", 32'(valid), 32'h0);

    // Serial with input held high
    pinIn = 17'h00001;
    setMode(2'd1);
    check("R7 upper pins kept", 32'(pinOut[15:2]), 32'(16'h1234 >> 2));
    word = 28'hA5C396E;
    @(negedge clk) begin wrEn = 1'b1; wrData = word; end
    @(negedge clk) wrEn = 1'b0;
    for (int j = 0; j < 28; j++) begin
      if (j > 0) @(negedge clk);
      check("R4 serial out bit", 32'(pinOut[0]), 32'(word[27-j]));
      check("R5 shift clock level", 32'(pinOut[1]), 32'(j % 2));
      check("R6 valid during transfer", 32'(valid), 32'h0);
    end
    @(negedge clk);
    check("R6 valid after 28 bits", 32'(valid), 32'h1);
    check("R6 received word", rdData, 32'h0FFFFFFF);
    check("R5 shift clock ends low", 32'(pinOut[1]), 32'h0);
    check("R7 upper pins after write", 32'(pinOut[15:2]), 32'(16'h1234 >> 2));

    // Serial with input held low
    pinIn = 17'h00000;
    repeat (2) @(negedge clk);
    @(negedge clk) begin wrEn = 1'b1; wrData = 28'h0000001; end
    @(negedge clk) wrEn = 1'b0;
    check("R6 load clears valid", 32'(valid), 32'h0);
    repeat (27) @(negedge clk);
    check("R4 last bit out", 32'(pinOut[0]), 32'h1);
    @(negedge clk);
    check("R6 valid second word", 32'(valid), 32'h1);
    check("R6 zeros received", rdData, 32'h0);

    // Table walk: parallel and nibble captures
    for (int i = 0; i < 6; i++) begin
      if (modeSel != VECS[i].mode) setMode(VECS[i].mode);
      capPulse(VECS[i].first);
      if (VECS[i].mode == 2'd3) begin
        check("R9 no valid after one nibble", 32'(valid), 32'h0);
        capPulse(VECS[i].second);
      end
      check(VECS[i].mode == 2'd2 ? "R8 valid" : "R9 valid", 32'(valid), 32'h1);
      check(VECS[i].mode == 2'd2 ? "R8 data" : "R9 byte", rdData, VECS[i].expData);
      @(negedge clk) rdEn = 1'b1;
      @(negedge clk) rdEn = 1'b0;
      check("R10 read clears valid", 32'(valid), 32'h0);
    end

    // R3 mode change clears valid
    setMode(2'd2);
    capPulse(16'h1357);
    check("R3 valid before switch", 32'(valid), 32'h1);
    @(negedge clk) modeSel = 2'd3;
    @(negedge clk);
    check("R3 valid cleared by mode change", 32'(valid), 32'h0);

    // R3 pending nibble dropped by mode change
    capPulse(16'h0009);
    setMode(2'd0);
    setMode(2'd3);
    capPulse(16'h0002);
    check("R3 pairing restarted", 32'(valid), 32'h0);
    capPulse(16'h0007);
    check("R3 valid after new pair", 32'(valid), 32'h1);
    check("R3 byte after restart", rdData, 32'h00000072);

    // R8 exact latency and R10 coincidence of read and capture
    setMode(2'd2);
    capPulse(16'h1111);
    check("R8 first word", rdData, 32'h00001111);
    @(negedge clk) pinIn = {1'b1, 16'h2222};
    @(negedge clk);
    check("R8 not yet captured", rdData, 32'h00001111);
    @(negedge clk) rdEn = 1'b1;
    @(negedge clk) rdEn = 1'b0;
    check("R10 valid kept on coincident completion", 32'(valid), 32'h1);
    check("R10 new word on coincidence", rdData, 32'h00002222);
    @(negedge clk) rdEn = 1'b1;
    @(negedge clk) rdEn = 1'b0;
    check("R10 lone read clears", 32'(valid), 32'h0);
    pinIn = {1'b0, 16'h2222};
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule